// File: doc/BRIEF.md
# Four-State Toggle Cell

The block is a toggle storage element driven by a strobe that is sampled on a fast system clock. It holds two state bits, a principal bit Q and a shadow bit P, and steps through a four-state walk. On each system-clock cycle both bits are updated by small level-controlled 2:1 selects. The strobe level picks between holding and following. The toggle enable picks between keeping Q and loading the inverse of P.

The net effect is that Q inverts once per strobe-high interval, in the first sampled cycle of that interval where the toggle enable is high. While the strobe is low, P catches up with Q, which re-arms the cell for the next interval. Both the strobe and the enable are plain synchronous inputs. They are expected to be already synchronised to the system clock. The cell is used wherever a divide-by-two or toggle-on-event function is needed from a strobe that is slow relative to the clock.

Top module: `tgl4_toggle_cell`

## Requirements
- R1: When `rst_i` is high at a rising clock edge, the state word {P,Q} becomes 00 at that edge, whatever the other inputs are.
- R2: A cycle with the strobe sampled low leaves Q unchanged.
- R3: A cycle with the strobe sampled low loads P with the current Q.
- R4: A cycle with the strobe sampled high leaves P unchanged.
- R5: A cycle with the strobe sampled high and the enable sampled low leaves Q unchanged.
- R6: A cycle with the strobe sampled high and the enable sampled high loads Q with the inverse of the current P.
- R7: Within one strobe-high interval that follows a strobe-low cycle, Q inverts exactly once, in the first cycle where the enable is sampled high. If the enable is never high in that interval, Q does not invert. Any later enable changes in that interval have no effect on Q.
- R8: A full toggle pair walks the encoded state {P,Q} through 00, 01, 11, 10 and back to 00. Each step is taken on one of these sampled inputs, in order: strobe high with enable high, strobe low, strobe high with enable high, strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising-edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Sampled strobe level |
| tgl_en_i | input | 1 | Toggle enable, sampled with the strobe |
| q_o | output | 1 | Principal state bit Q |
| p_o | output | 1 | Shadow state bit P |

## Verification
The properties assume that the strobe and enable are already synchronous to the system clock and are settled at every rising edge. They also assume that reset is the only way the state is forced. The bench drives every input at the falling edge, half a period away from the sampling edge, so each input is stable when it is sampled. The stimulus includes enable pulses that rise and fall in the middle of strobe-high intervals, both before and after the toggle has happened. It also includes strobe intervals of a single cycle and reset asserted together with an active strobe.

// File: rtl/tgl4_pkg.sv
package tgl4_pkg;
  typedef struct packed {
    logic p;
    logic q;
  } tgl4_state_t;

  localparam tgl4_state_t TGL4_ZERO = '{p: 1'b0, q: 1'b0};
endpackage

// File: rtl/tgl4_sel2.sv
module tgl4_sel2 #(
  parameter int W = 1
) (
  input  logic         sel_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] y_o
);
  always_comb y_o = sel_i ? hi_i : lo_i;
endmodule

// File: rtl/tgl4_next.sv
module tgl4_next
  import tgl4_pkg::*;
(
  input  tgl4_state_t cur_i,
  input  logic        strobe_i,
  input  logic        tgl_en_i,
  output tgl4_state_t nxt_o
);
  logic not_p;
  logic q_when_high;
  logic p_nxt;
  logic q_nxt;

  always_comb not_p = ~cur_i.p;

  // strobe low: P follows Q; strobe high: P holds
  tgl4_sel2 #(.W(1)) u_psel (
    .sel_i(strobe_i), .lo_i(cur_i.q), .hi_i(cur_i.p), .y_o(p_nxt)
  );

  // enable chooses keep-Q or inverse of P
  tgl4_sel2 #(.W(1)) u_tsel (
    .sel_i(tgl_en_i), .lo_i(cur_i.q), .hi_i(not_p), .y_o(q_when_high)
  );

  // strobe low: Q holds; strobe high: enable-selected value
  tgl4_sel2 #(.W(1)) u_qsel (
    .sel_i(strobe_i), .lo_i(cur_i.q), .hi_i(q_when_high), .y_o(q_nxt)
  );

  always_comb begin
    nxt_o.p = p_nxt;
    nxt_o.q = q_nxt;
  end
endmodule

// File: rtl/tgl4_reg.sv
module tgl4_reg
  import tgl4_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  tgl4_state_t d_i,
  output tgl4_state_t q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= TGL4_ZERO;
    else       q_o <= d_i;
  end
endmodule

// File: rtl/tgl4_toggle_cell.sv
module tgl4_toggle_cell
  import tgl4_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  input  logic tgl_en_i,
  output logic q_o,
  output logic p_o
);
  tgl4_state_t st_cur;
  tgl4_state_t st_nxt;

  tgl4_next u_next (
    .cur_i(st_cur), .strobe_i(strobe_i), .tgl_en_i(tgl_en_i), .nxt_o(st_nxt)
  );

  tgl4_reg u_reg (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(st_nxt), .q_o(st_cur)
  );

  always_comb begin
    q_o = st_cur.q;
    p_o = st_cur.p;
  end
endmodule

// File: rtl/tgl4_toggle_chk.sv
module tgl4_toggle_chk (
  input logic clk,
  input logic rst,
  input logic strobe,
  input logic tgl,
  input logic p,
  input logic q
);
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (!p && !q));

  a_r2_low_holds_q: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> (q == $past(q)));

  a_r3_low_loads_p: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> (p == $past(q)));

  a_r4_high_holds_p: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (p == $past(p)));

  a_r5_high_noen_holds_q: assert property (@(posedge clk) disable iff (rst)
    (strobe && !tgl) |=> (q == $past(q)));

  a_r6_high_en_inverts: assert property (@(posedge clk) disable iff (rst)
    (strobe && tgl) |=> (q == !$past(p)));

  // R7: once toggled in an interval (P != Q), further high cycles keep Q
  a_r7_single_toggle: assert property (@(posedge clk) disable iff (rst)
    (strobe && (p != q)) |=> $stable(q));
endmodule

bind tgl4_toggle_cell tgl4_toggle_chk u_chk (
  .clk(clk_i), .rst(rst_i), .strobe(strobe_i), .tgl(tgl_en_i),
  .p(p_o), .q(q_o)
);

// File: tb/tb_tgl4_toggle_cell.sv
module tb_tgl4_toggle_cell;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic tgl = 1'b0;
  logic q, p;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  tgl4_toggle_cell dut (
    .clk_i(clk), .rst_i(rst), .strobe_i(strobe), .tgl_en_i(tgl),
    .q_o(q), .p_o(p)
  );

  // {rst, strobe, enable, expected P, expected Q after the edge}
  localparam int NV = 19;
  localparam logic [4:0] VEC [NV] = '{
    5'b10000, 5'b01101, 5'b01001, 5'b01101, 5'b00011,
    5'b00111, 5'b01011, 5'b01110, 5'b01010, 5'b00000,
    5'b01000, 5'b00100, 5'b01101, 5'b00111, 5'b01110,
    5'b00100, 5'b01101, 5'b11100, 5'b01101
  };

  function automatic string tag_q(input logic r, input logic s, input logic t);
    if (r) return "R1";
    if (!s) return "R2";
    return t ? "R6" : "R5";
  endfunction

  function automatic string tag_p(input logic r, input logic s);
    if (r) return "R1";
    return s ? "R4" : "R3";
  endfunction

  task automatic cmp(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic t);
    @(negedge clk);
    rst = r; strobe = s; tgl = t;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ref_q, ref_p, used, prev_s;
    logic [7:0] lfsr;

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      cmp(tag_p(VEC[i][4], VEC[i][3]), p, VEC[i][1]);
      cmp(tag_q(VEC[i][4], VEC[i][3], VEC[i][2]), q, VEC[i][0]);
    end

    // R8: four-state walk from reset
    step(1'b1, 1'b0, 1'b0);
    cmp("R1", {p, q} == 2'b00, 1'b1);
    step(1'b0, 1'b1, 1'b1); cmp("R8 state 01", {p, q} == 2'b01, 1'b1);
    step(1'b0, 1'b0, 1'b1); cmp("R8 state 11", {p, q} == 2'b11, 1'b1);
    step(1'b0, 1'b1, 1'b1); cmp("R8 state 10", {p, q} == 2'b10, 1'b1);
    step(1'b0, 1'b0, 1'b1); cmp("R8 state 00", {p, q} == 2'b00, 1'b1);

    // R7: enable pulse mid-interval after a toggle is ignored
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    cmp("R7 late enable ignored", q, 1'b1);
    step(1'b0, 1'b0, 1'b0);

    // R7: reference toggles on the first enabled cycle of each high interval
    ref_q = q; ref_p = q; used = 1'b0; prev_s = 1'b0; lfsr = 8'hA5;
    for (int i = 0; i < 600; i++) begin
      logic s, t;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      s = (i % 9) < 4 || lfsr[0];
      t = lfsr[2];
      step(1'b0, s, t);
      if (!s) begin
        used = 1'b0;
        ref_p = ref_q;
      end else if (t && !used) begin
        ref_q = ~ref_q;
        used = 1'b1;
      end
      prev_s = s;
      cmp("R7 toggle count", q, ref_q);
      cmp(s ? "R4" : "R3", p, ref_p);
    end

    // R1: reset wins over an active strobe with enable
    step(1'b1, 1'b1, 1'b1);
    cmp("R1 reset dominant", {p, q} == 2'b00, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule